// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 128-bit packed integer execution unit. Each cycle it can take two 128-bit source words, an operation code, a lane-size select and a 7-bit immediate. It splits the words into independent lanes and applies the selected operation to every lane at once. The lane-size select divides the datapath into four 32-bit lanes, eight 16-bit lanes or sixteen 8-bit lanes.

The operations are wrapping add and subtract, signed and unsigned minimum and maximum, four bitwise logic functions, three shifts and a per-lane leading-zero count. A funnel shift is also provided: it joins the two operands into one 256-bit value and extracts a 128-bit window at the offset given by the immediate.

The result goes through one register stage. A new operation can be issued on every cycle. An operation code or lane-size select that the block does not recognise gives a zero result and raises an illegal flag.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `out_illegal` and `result` become zero.
- R2: `out_valid` is `in_valid` delayed by one clock. The result of an operation issued in cycle N appears in cycle N+1, and a different operation can be issued in every consecutive cycle. When `in_valid` is low, `result` keeps its previous value.
- R3: `lane_mode` 0 selects 32-bit lanes, 1 selects 16-bit lanes and 2 selects 8-bit lanes. Lane k covers bits [k*W+W-1 : k*W]. Opcode 0 (add) and opcode 1 (subtract, a minus b) wrap modulo 2^W, and no carry or borrow crosses from one lane into the next.
- R4: Opcode 2 gives the unsigned minimum and opcode 3 the unsigned maximum of each lane pair. Opcode 6 gives the signed minimum and opcode 7 the signed maximum, with two's-complement lanes.
- R5: Opcodes 4, 5, 8 and 9 give the bitwise AND, OR, XOR and NOR of the operands, for any legal lane mode.
- R6: Opcode 10 is a logical left shift, 11 a logical right shift and 12 an arithmetic right shift. Each lane of `src_a` is shifted by the low log2(W) bits of the matching lane of `src_b`.
- R7: Opcode 13 writes into each lane the number of leading zero bits of that lane of `src_a`. A lane that is all zero gives W.
- R8: Opcode 14 forms the 256-bit value {`src_a`, `src_b`} and returns bits [`shift_imm`+127 : `shift_imm`]. An offset of 0 returns `src_b` unchanged. This operation ignores `lane_mode`, including value 3.
- R9: Opcode 15, or `lane_mode` 3 with any opcode other than 14, gives an all-zero `result` and sets `out_illegal` in the same cycle as `out_valid`. `out_illegal` is low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| op | input | 4 | Operation code |
| lane_mode | input | 2 | Lane size: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit |
| src_a | input | 128 | First operand, high half for the funnel shift |
| src_b | input | 128 | Second operand, shift amounts, low half for the funnel shift |
| shift_imm | input | 7 | Funnel window offset |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_illegal | output | 1 | Unrecognised operation flag |
| result | output | 128 | Registered result |

## Verification
The bench puts carries and borrows exactly at lane edges, so a datapath that let them leak into the next lane shows a changed neighbour lane. It compares values whose sign bits differ under both signed and unsigned minimum and maximum, which catches a swapped signedness. It shifts by amounts above the lane width, which catches a missing modulo, and shifts negative lanes arithmetically, which catches a zero fill in place of sign fill. It also covers all-zero lanes for the leading-zero count, funnel offsets of 0, 1 and 127, reserved opcodes and lane modes, and back-to-back issue. A wrong lane count, an off-by-one window or a stale pipeline register would each give a wrong value in a named lane.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int SIMD_DATA_W = 128;
    localparam int SIMD_NUM_MODES = 3;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MINU = 4'h2,
        OP_MAXU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_MINS = 4'h6,
        OP_MAXS = 4'h7,
        OP_XOR  = 4'h8,
        OP_NOR  = 4'h9,
        OP_SLL  = 4'hA,
        OP_SRL  = 4'hB,
        OP_SRA  = 4'hC,
        OP_LZC  = 4'hD,
        OP_FSH  = 4'hE,
        OP_RSV  = 4'hF
    } simd_op_e;

    typedef enum logic [1:0] {
        LM_W32 = 2'd0,
        LM_W16 = 2'd1,
        LM_W8  = 2'd2,
        LM_RSV = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic                   valid;
        logic                   illegal;
        logic [SIMD_DATA_W-1:0] data;
    } simd_out_t;

    function automatic logic op_is_illegal(simd_op_e op, lane_mode_e lm);
        return (op == OP_RSV) || ((lm == LM_RSV) && (op != OP_FSH));
    endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_pkg::*;
#(
    parameter int DW = 128,
    parameter int LW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  simd_op_e      op_i,
    output logic [DW-1:0] res_o
);
    localparam int NL = DW / LW;
    localparam int SW = $clog2(LW);
    localparam int CW = SW + 1;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] la, lb, lr;
        logic [SW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          lt_u, lt_s;

        assign la   = a_i[i*LW +: LW];
        assign lb   = b_i[i*LW +: LW];
        assign sh   = lb[SW-1:0];
        assign lt_u = la < lb;
        assign lt_s = $signed(la) < $signed(lb);

        always_comb begin
            cnt = CW'(LW);
            for (int k = 0; k < LW; k++) begin
                if (la[k]) cnt = CW'(LW - 1 - k);
            end
        end

        always_comb begin
            case (op_i)
                OP_ADD:  lr = la + lb;
                OP_SUB:  lr = la - lb;
                OP_MINU: lr = lt_u ? la : lb;
                OP_MAXU: lr = lt_u ? lb : la;
                OP_MINS: lr = lt_s ? la : lb;
                OP_MAXS: lr = lt_s ? lb : la;
                OP_AND:  lr = la & lb;
                OP_OR:   lr = la | lb;
                OP_XOR:  lr = la ^ lb;
                OP_NOR:  lr = ~(la | lb);
                OP_SLL:  lr = la << sh;
                OP_SRL:  lr = la >> sh;
                OP_SRA:  lr = LW'($signed(la) >>> sh);
                OP_LZC:  lr = {{(LW-CW){1'b0}}, cnt};
                default: lr = '0;
            endcase
        end

        assign res_o[i*LW +: LW] = lr;
    end

endmodule

// File: rtl/simd_funnel.sv
module simd_funnel #(
    parameter int DW = 128,
    parameter int OW = 7
) (
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    input  logic [OW-1:0] off_i,
    output logic [DW-1:0] res_o
);
    logic [2*DW-1:0] joined;

    assign joined = {hi_i, lo_i};
    assign res_o  = joined[off_i +: DW];

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = SIMD_DATA_W,
    parameter int OFF_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        lane_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [OFF_W-1:0]  shift_imm,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [DATA_W-1:0] result
);
    simd_op_e    opc;
    lane_mode_e  lmode;
    logic        bad_op;
    logic [DATA_W-1:0] lane_res [SIMD_NUM_MODES];
    logic [DATA_W-1:0] fsh_res;
    logic [DATA_W-1:0] next_res;

    assign opc    = simd_op_e'(op);
    assign lmode  = lane_mode_e'(lane_mode);
    assign bad_op = op_is_illegal(opc, lmode);

    for (genvar g = 0; g < SIMD_NUM_MODES; g++) begin : g_width
        simd_lane_unit #(
            .DW (DATA_W),
            .LW (32 >> g)
        ) u_lanes (
            .a_i   (src_a),
            .b_i   (src_b),
            .op_i  (opc),
            .res_o (lane_res[g])
        );
    end

    simd_funnel #(
        .DW (DATA_W),
        .OW (OFF_W)
    ) u_funnel (
        .hi_i  (src_a),
        .lo_i  (src_b),
        .off_i (shift_imm),
        .res_o (fsh_res)
    );

    always_comb begin
        if (bad_op)              next_res = '0;
        else if (opc == OP_FSH)  next_res = fsh_res;
        else begin
            case (lmode)
                LM_W32:  next_res = lane_res[0];
                LM_W16:  next_res = lane_res[1];
                LM_W8:   next_res = lane_res[2];
                default: next_res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            result      <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid & bad_op;
            if (in_valid) result <= next_res;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_valid && (result == '0)));

    // R8
    funnel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'hE) && (shift_imm == '0)) |=> (result == $past(src_b)));

    // R7
    lzc_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'hD) && (lane_mode == 2'd2) && (src_a == '0))
        |=> (result == {(DATA_W/8){8'h08}}));

endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [3:0]   op;
    logic [1:0]   lane_mode;
    logic [127:0] src_a, src_b;
    logic [6:0]   shift_imm;
    logic         out_valid, out_illegal;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    simd_alu u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_mode(lane_mode),
        .src_a(src_a), .src_b(src_b), .shift_imm(shift_imm),
        .out_valid(out_valid), .out_illegal(out_illegal), .result(result)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] md,
                                           input logic [127:0] a, input logic [127:0] b,
                                           input logic [6:0] imm);
        logic [255:0] cat;
        logic [127:0] r;
        int w, n;
        logic [31:0] m, la, lb, lr, sb, sh;
        if (o == 4'hF) return '0;
        if (o == 4'hE) begin
            cat = {a, b} >> imm;
            return cat[127:0];
        end
        if (md == 2'd3) return '0;
        w  = 32 >> md;
        n  = 128 / w;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        sb = 32'd1 << (w - 1);
        r  = '0;
        for (int i = 0; i < n; i++) begin
            la = 32'(a >> (i * w)) & m;
            lb = 32'(b >> (i * w)) & m;
            sh = lb & (w - 1);
            case (o)
                4'h0: lr = (la + lb) & m;
                4'h1: lr = (la - lb) & m;
                4'h2: lr = (la < lb) ? la : lb;
                4'h3: lr = (la < lb) ? lb : la;
                4'h6: lr = ((la ^ sb) < (lb ^ sb)) ? la : lb;
                4'h7: lr = ((la ^ sb) < (lb ^ sb)) ? lb : la;
                4'h4: lr = la & lb;
                4'h5: lr = la | lb;
                4'h8: lr = la ^ lb;
                4'h9: lr = ~(la | lb) & m;
                4'hA: lr = (la << sh) & m;
                4'hB: lr = la >> sh;
                4'hC: lr = (la >> sh) | (((la & sb) != 0) ? (m & ~(m >> sh)) : 32'd0);
                4'hD: begin
                    lr = w;
                    for (int k = 0; k < w; k++) if (la[k]) lr = w - 1 - k;
                end
                default: lr = 0;
            endcase
            r = r | (128'(lr) << (i * w));
        end
        return r;
    endfunction

    task automatic issue(input logic [3:0] o, input logic [1:0] md,
                         input logic [127:0] a, input logic [127:0] b,
                         input logic [6:0] imm, input string req);
        logic ill;
        ill = (o == 4'hF) || (md == 2'd3 && o != 4'hE);
        @(negedge clk);
        in_valid = 1'b1; op = o; lane_mode = md; src_a = a; src_b = b; shift_imm = imm;
        @(posedge clk); #1;
        check({req, " valid"}, 128'(out_valid), 128'd1);
        check({req, " illegal"}, 128'(out_illegal), 128'(ill));
        check(req, result, model(o, md, a, b, imm));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; op = 4'h5; lane_mode = 2'd0;
        src_a = '1; src_b = '1; shift_imm = '0;
        @(posedge clk); #1;
        check("R1 valid", 128'(out_valid), 128'd0);
        check("R1 illegal", 128'(out_illegal), 128'd0);
        check("R1 result", result, 128'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_addsub;
        issue(4'h0, 2'd0, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 0, "R3 add32 wrap");
        issue(4'h0, 2'd1, {8{16'hFFFF}}, {8{16'h0001}}, 0, "R3 add16 wrap");
        issue(4'h0, 2'd2, 128'h80FF_7F01_00FF_FE12_3456_789A_BCDE_F001, {16{8'h81}}, 0, "R3 add8 mix");
        issue(4'h1, 2'd2, {16{8'h00}}, {16{8'h01}}, 0, "R3 sub8 borrow");
        issue(4'h1, 2'd0, 128'h0000_0000_0000_0001_8000_0000_1234_5678, {4{32'h0000_0002}}, 0, "R3 sub32");
    endtask

    task automatic t_minmax;
        logic [127:0] a, b;
        a = {8{16'h8000}};
        b = {8{16'h0001}};
        issue(4'h2, 2'd1, a, b, 0, "R4 minu16");
        issue(4'h3, 2'd1, a, b, 0, "R4 maxu16");
        issue(4'h6, 2'd1, a, b, 0, "R4 mins16");
        issue(4'h7, 2'd1, a, b, 0, "R4 maxs16");
        issue(4'h6, 2'd2, 128'h7F80_FF01_0102_80FE_1122_3344_5566_7788,
                          128'h807F_01FF_0201_FE80_8877_6655_4433_2211, 0, "R4 mins8");
        issue(4'h3, 2'd0, 128'hFFFF_FFFF_0000_0001_7FFF_FFFF_8000_0000,
                          128'h0000_0001_FFFF_FFFF_8000_0000_7FFF_FFFF, 0, "R4 maxu32");
    endtask

    task automatic t_logic;
        logic [127:0] a, b;
        a = 128'hF0F0_1234_5678_9ABC_DEF0_0F0F_AAAA_5555;
        b = 128'hFF00_FF00_0F0F_F0F0_1234_5678_5555_AAAA;
        issue(4'h4, 2'd0, a, b, 0, "R5 and");
        issue(4'h5, 2'd1, a, b, 0, "R5 or");
        issue(4'h8, 2'd2, a, b, 0, "R5 xor");
        issue(4'h9, 2'd0, a, b, 0, "R5 nor");
    endtask

    task automatic t_shift;
        issue(4'hA, 2'd0, {4{32'h8000_0001}}, 128'h0000_0001_0000_001F_0000_0020_0000_0023, 0, "R6 sll32 mod");
        issue(4'hB, 2'd1, {8{16'h8001}}, 128'h0000_0001_000F_0010_0011_0003_0008_FFFF, 0, "R6 srl16");
        issue(4'hC, 2'd2, {8{8'h80, 8'h40}}, 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F, 0, "R6 sra8");
        issue(4'hC, 2'd0, {2{32'hF000_0000, 32'h7000_0000}}, {4{32'h0000_0024}}, 0, "R6 sra32 mod");
    endtask

    task automatic t_lzc;
        issue(4'hD, 2'd2, 128'h0001_0204_0810_2040_80FF_7F3F_1F0F_0703, '0, 0, "R7 lzc8");
        issue(4'hD, 2'd2, '0, '0, 0, "R7 lzc8 zero");
        issue(4'hD, 2'd0, 128'h0000_0000_0000_0001_8000_0000_0001_0000, '0, 0, "R7 lzc32");
        issue(4'hD, 2'd1, 128'h0000_0001_8000_00FF_0100_7FFF_0002_0000, '0, 0, "R7 lzc16");
    endtask

    task automatic t_funnel;
        logic [127:0] a, b;
        a = 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_1111_2222;
        b = 128'h3333_4444_5555_6666_7777_8888_9999_0001;
        issue(4'hE, 2'd0, a, b, 7'd0, "R8 off0");
        issue(4'hE, 2'd2, a, b, 7'd1, "R8 off1");
        issue(4'hE, 2'd1, a, b, 7'd64, "R8 off64");
        issue(4'hE, 2'd3, a, b, 7'd127, "R8 off127 mode3");
    endtask

    task automatic t_illegal;
        issue(4'hF, 2'd0, '1, '1, 0, "R9 op15");
        issue(4'h0, 2'd3, '1, '1, 0, "R9 mode3");
        issue(4'hD, 2'd3, '0, '0, 0, "R9 mode3 lzc");
    endtask

    task automatic t_pipeline;
        logic [127:0] a0, b0, a1, b1;
        logic [127:0] held;
        a0 = {4{32'h1234_5678}}; b0 = {4{32'h1111_1111}};
        a1 = {16{8'hF0}};        b1 = {16{8'h03}};
        @(negedge clk);
        in_valid = 1'b1; op = 4'h0; lane_mode = 2'd0; src_a = a0; src_b = b0; shift_imm = 0;
        @(negedge clk);
        check("R2 first out", result, model(4'h0, 2'd0, a0, b0, 0));
        op = 4'hC; lane_mode = 2'd2; src_a = a1; src_b = b1;
        @(negedge clk);
        check("R2 second out", result, model(4'hC, 2'd2, a1, b1, 0));
        check("R2 second valid", 128'(out_valid), 128'd1);
        op = 4'hF;
        @(negedge clk);
        check("R2 third illegal", 128'(out_illegal), 128'd1);
        in_valid = 1'b0; op = 4'h0; src_a = '1; src_b = '1;
        held = result;
        @(negedge clk);
        check("R2 idle valid", 128'(out_valid), 128'd0);
        check("R2 idle illegal", 128'(out_illegal), 128'd0);
        check("R2 idle hold", result, held);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; lane_mode = '0;
        src_a = '0; src_b = '0; shift_imm = '0;
        repeat (2) @(posedge clk);
        t_reset();
        t_addsub();
        t_minmax();
        t_logic();
        t_shift();
        t_lzc();
        t_funnel();
        t_illegal();
        t_pipeline();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule